// File: doc/BRIEF.md
# Power-Up and Sleep Sequencer

This block controls how a system-basis chip brings up its companion microcontroller. After the power-on reset is released, it waits a fixed settling interval. It then switches on the microcontroller supply and watches two rail-good flags for a bounded time. If both rails come good inside that window, it gates the microcontroller clock on, lets the microcontroller out of reset and stays in its run mode. If they do not, it falls back to a low-power sleep mode and hands the system clock to the slow oscillator.

While asleep, the block waits for a LIN wake-up pulse from an external pattern detector. The pulse does not lead straight to run mode. It starts a new supply check, which ends in run mode if both rails come good and in sleep again if the window runs out. Both interval lengths are parameters counted in clock cycles. The power-on reset acts asynchronously, and its release is synchronised to the clock inside the block.

Top module: `sbc_pwrup_seq`

## Requirements
- R1: While `por_n` is low, `mode` is 0, `mcu_pwr_en` and `mcu_clk_en` are 0, `mcu_rst_n` is 0 and `clk_sel_slow` is 0.
- R2: After reset is released, the block spends exactly `STAB_CYC` cycles with `mode`=1 and `mcu_pwr_en`=0.
- R3: When the settling interval ends, `mcu_pwr_en` goes to 1 while `mode` stays 1, and a check window of `CHK_CYC` cycles starts counting from zero.
- R4: The supply counts as good only in a cycle where `vdd18_ok` and `vdd33_ok` are both 1. One rail alone never counts.
- R5: When the supply is good during a check cycle, the next cycle shows `mode`=2 with `mcu_pwr_en`=1, `mcu_clk_en`=1 and `mcu_rst_n`=1.
- R6: If the supply is not good in any of the `CHK_CYC` check cycles, the block enters sleep (`mode`=3) right after the last one. A good supply seen in that last cycle still leads to run mode.
- R7: In sleep, `mcu_pwr_en`=0, `mcu_clk_en`=0 and `mcu_rst_n`=0. The block stays asleep, whatever the rail flags show, until a wake-up pulse arrives.
- R8: A `lin_wake` pulse in sleep puts the block back in a check (`mode`=1, `mcu_pwr_en`=1) with a fresh `CHK_CYC` window. The check ends by R5 or R6.
- R9: `clk_sel_slow` is 1 exactly when `mode` is 3 and 0 in every other mode.
- R10: A `lin_wake` pulse outside sleep has no effect. In particular, run mode stays in run mode.
- R11: `mode` encodes reset=0, start-up (settling or checking)=1, run=2, sleep=3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| vdd18_ok | input | 1 | 1.8 V rail good flag |
| vdd33_ok | input | 1 | 3.3 V rail good flag |
| lin_wake | input | 1 | Wake-up pulse from the LIN detector |
| mcu_pwr_en | output | 1 | Microcontroller supply enable |
| mcu_clk_en | output | 1 | Microcontroller clock enable |
| mcu_rst_n | output | 1 | Microcontroller reset, active low |
| clk_sel_slow | output | 1 | 1 selects the slow oscillator, 0 the main-oscillator clock |
| mode | output | 2 | Sequencer mode code (see R11) |

## Verification
The bench builds the block with `STAB_CYC`=5 and `CHK_CYC`=4, instead of the thousands of cycles a real settling time needs. With these short windows, the bench can count the exact length of each interval cycle by cycle. It can also reach a full timeout into sleep several times in one run. The short windows also bring within reach the edge case where the rails come good in the very last check cycle, and repeated wake-ups whose check windows must each restart from zero.

// File: rtl/sbc_seq_pkg.sv
package sbc_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETTLE = 3'd1,
    ST_CHECK  = 3'd2,
    ST_RUN    = 3'd3,
    ST_SLEEP  = 3'd4
  } seq_state_e;

  typedef enum logic [1:0] {
    MODE_RESET   = 2'd0,
    MODE_STARTUP = 2'd1,
    MODE_RUN     = 2'd2,
    MODE_SLEEP   = 2'd3
  } seq_mode_e;
endpackage

// File: rtl/seq_rst_sync.sv
module seq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n = chain_q[STAGES-1];
endmodule

// File: rtl/seq_cnt.sv
module seq_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] count
);
  logic [W-1:0] count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count_q <= '0;
    else if (clr) count_q <= '0;
    else if (inc) count_q <= count_q + 1'b1;
  end

  assign count = count_q;
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import sbc_seq_pkg::*;
#(
  parameter int STAB_CYC = 4000,
  parameter int CHK_CYC  = 2000,
  parameter int CW       = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rail_good,
  input  logic          wake,
  input  logic [CW-1:0] count,
  output logic          cnt_clr,
  output logic          cnt_inc,
  output logic          pwr_en,
  output logic          clk_en,
  output logic          mcu_rel,
  output logic          sel_slow,
  output logic [1:0]    mode
);
  localparam logic [CW-1:0] STAB_LAST = CW'(STAB_CYC - 1);
  localparam logic [CW-1:0] CHK_LAST  = CW'(CHK_CYC - 1);

  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    cnt_clr = 1'b0;
    cnt_inc = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        state_d = ST_SETTLE;
        cnt_clr = 1'b1;
      end
      ST_SETTLE: begin
        if (count == STAB_LAST) begin
          state_d = ST_CHECK;
          cnt_clr = 1'b1;
        end else begin
          cnt_inc = 1'b1;
        end
      end
      ST_CHECK: begin
        if (rail_good) begin
          state_d = ST_RUN;
        end else if (count == CHK_LAST) begin
          state_d = ST_SLEEP;
        end else begin
          cnt_inc = 1'b1;
        end
      end
      ST_RUN: state_d = ST_RUN;
      ST_SLEEP: begin
        if (wake) begin
          state_d = ST_CHECK;
          cnt_clr = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    pwr_en   = (state_q == ST_CHECK) || (state_q == ST_RUN);
    clk_en   = (state_q == ST_RUN);
    mcu_rel  = (state_q == ST_RUN);
    sel_slow = (state_q == ST_SLEEP);
    unique case (state_q)
      ST_SETTLE, ST_CHECK: mode = MODE_STARTUP;
      ST_RUN:              mode = MODE_RUN;
      ST_SLEEP:            mode = MODE_SLEEP;
      default:             mode = MODE_RESET;
    endcase
  end
endmodule

// File: rtl/sbc_pwrup_seq.sv
module sbc_pwrup_seq #(
  parameter int STAB_CYC = 4000,
  parameter int CHK_CYC  = 2000,
  parameter int SYNC_STG = 2
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       vdd18_ok,
  input  logic       vdd33_ok,
  input  logic       lin_wake,
  output logic       mcu_pwr_en,
  output logic       mcu_clk_en,
  output logic       mcu_rst_n,
  output logic       clk_sel_slow,
  output logic [1:0] mode
);
  localparam int MAXC = (STAB_CYC > CHK_CYC) ? STAB_CYC : CHK_CYC;
  localparam int CW   = (MAXC > 2) ? $clog2(MAXC) : 1;

  logic          rst_n;
  logic          cnt_clr, cnt_inc;
  logic [CW-1:0] count;

  seq_rst_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk    (clk),
    .arst_n (por_n),
    .rst_n  (rst_n)
  );

  seq_cnt #(.W(CW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .inc   (cnt_inc),
    .count (count)
  );

  seq_fsm #(.STAB_CYC(STAB_CYC), .CHK_CYC(CHK_CYC), .CW(CW)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .rail_good (vdd18_ok & vdd33_ok),
    .wake      (lin_wake),
    .count     (count),
    .cnt_clr   (cnt_clr),
    .cnt_inc   (cnt_inc),
    .pwr_en    (mcu_pwr_en),
    .clk_en    (mcu_clk_en),
    .mcu_rel   (mcu_rst_n),
    .sel_slow  (clk_sel_slow),
    .mode      (mode)
  );
endmodule

// File: rtl/sbc_pwrup_seq_chk.sv
module sbc_pwrup_seq_chk (
  input logic       clk,
  input logic       por_n,
  input logic       vdd18_ok,
  input logic       vdd33_ok,
  input logic       lin_wake,
  input logic       mcu_pwr_en,
  input logic       mcu_clk_en,
  input logic       mcu_rst_n,
  input logic       clk_sel_slow,
  input logic [1:0] mode
);
  AST_POR_QUIET: assert property (@(posedge clk)
    !por_n |-> (mode == 2'd0 && !mcu_pwr_en && !mcu_clk_en && !mcu_rst_n)); // R1

  AST_CLK_AFTER_PWR: assert property (@(posedge clk) disable iff (!por_n)
    mcu_clk_en |-> mcu_pwr_en); // R5

  AST_RUN_NEEDS_RAILS: assert property (@(posedge clk) disable iff (!por_n)
    (mode == 2'd2 && $past(mode) != 2'd2) |-> $past(vdd18_ok && vdd33_ok)); // R4

  AST_SLEEP_OFF: assert property (@(posedge clk) disable iff (!por_n)
    (mode == 2'd3) |-> (!mcu_pwr_en && !mcu_clk_en && !mcu_rst_n)); // R7

  AST_SLEEP_EXIT: assert property (@(posedge clk) disable iff (!por_n)
    ($past(mode) == 2'd3 && mode != 2'd3) |-> (mode == 2'd1 && $past(lin_wake))); // R8

  AST_SLOW_SEL: assert property (@(posedge clk) disable iff (!por_n)
    clk_sel_slow == (mode == 2'd3)); // R9

  AST_RUN_HOLD: assert property (@(posedge clk) disable iff (!por_n)
    ($past(mode) == 2'd2) |-> (mode == 2'd2)); // R10
endmodule

bind sbc_pwrup_seq sbc_pwrup_seq_chk u_chk (
  .clk          (clk),
  .por_n        (por_n),
  .vdd18_ok     (vdd18_ok),
  .vdd33_ok     (vdd33_ok),
  .lin_wake     (lin_wake),
  .mcu_pwr_en   (mcu_pwr_en),
  .mcu_clk_en   (mcu_clk_en),
  .mcu_rst_n    (mcu_rst_n),
  .clk_sel_slow (clk_sel_slow),
  .mode         (mode)
);

// File: tb/sbc_pwrup_seq_bench.sv
`timescale 1ns/1ps
module sbc_pwrup_seq_bench;
  localparam int STAB = 5;
  localparam int CHK  = 4;

  logic clk = 1'b0;
  logic por_n, v18, v33, wake;
  logic pwr_en, clk_en, rst_n_o, sel_slow;
  logic [1:0] mode;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  sbc_pwrup_seq #(.STAB_CYC(STAB), .CHK_CYC(CHK)) u_sbc_pwrup_seq (
    .clk(clk), .por_n(por_n), .vdd18_ok(v18), .vdd33_ok(v33), .lin_wake(wake),
    .mcu_pwr_en(pwr_en), .mcu_clk_en(clk_en), .mcu_rst_n(rst_n_o),
    .clk_sel_slow(sel_slow), .mode(mode)
  );

  // Reference model: phase 0 reset, 1 settle, 2 check, 3 run, 4 sleep
  int ph, tick;
  bit s0, s1;

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      ph = 0; tick = 0; s0 = 0; s1 = 0;
    end else begin
      if (!s1) begin
        ph = 0; tick = 0;
      end else if (ph == 0) begin
        ph = 1; tick = 0;
      end else if (ph == 1) begin
        if (tick + 1 >= STAB) begin ph = 2; tick = 0; end
        else tick++;
      end else if (ph == 2) begin
        if (v18 && v33) ph = 3;
        else if (tick + 1 >= CHK) ph = 4;
        else tick++;
      end else if (ph == 4 && wake) begin
        ph = 2; tick = 0;
      end
      s1 = s0; s0 = 1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare against model every cycle
  always @(negedge clk) begin
    #1;
    if (!done) begin
      int em;
      em = (ph == 0) ? 0 : (ph <= 2) ? 1 : (ph == 3) ? 2 : 3;
      chk("R11 mode model", mode, em);
      chk("R3 pwr_en model", pwr_en, (ph == 2 || ph == 3));
      chk("R5 clk_en model", clk_en, (ph == 3));
      chk("R5 mcu_rst_n model", rst_n_o, (ph == 3));
      chk("R9 clk_sel_slow model", sel_slow, (ph == 4));
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_mode(input int m);
    for (int i = 0; i < 100 && mode != m; i++) step(1);
  endtask

  task automatic pulse_wake;
    wake = 1'b1; step(1); wake = 1'b0;
  endtask

  initial begin
    int n;
    por_n = 0; v18 = 0; v33 = 0; wake = 0;
    step(3);
    chk("R1 mode", mode, 0);
    chk("R1 pwr_en", pwr_en, 0);
    chk("R1 clk_en", clk_en, 0);
    chk("R1 mcu_rst_n", rst_n_o, 0);
    chk("R1 clk_sel_slow", sel_slow, 0);

    // Only one rail good: settle, check, time out
    v18 = 1;
    por_n = 1;
    wait_mode(1);
    n = 0;
    while (mode == 1 && !pwr_en && n < 50) begin n++; step(1); end
    chk("R2 settle length", n, STAB);
    chk("R3 pwr_en on in check", pwr_en, 1);
    chk("R3 mode in check", mode, 1);
    n = 0;
    while (mode == 1 && n < 50) begin n++; step(1); end
    chk("R6 check window length", n, CHK);
    chk("R4 one rail gives sleep", mode, 3);
    chk("R7 sleep pwr_en", pwr_en, 0);
    chk("R7 sleep mcu_rst_n", rst_n_o, 0);
    chk("R9 slow clock in sleep", sel_slow, 1);

    // Rails good but no wake: stay asleep
    v33 = 1;
    step(4);
    chk("R7 sleep holds without wake", mode, 3);
    pulse_wake();
    chk("R8 wake enters check", mode, 1);
    chk("R8 wake pwr_en", pwr_en, 1);
    step(1);
    chk("R5 run mode", mode, 2);
    chk("R5 clk_en", clk_en, 1);
    chk("R5 mcu_rst_n", rst_n_o, 1);
    chk("R9 fast clock in run", sel_slow, 0);

    // Wake in run mode ignored
    pulse_wake();
    step(2);
    chk("R10 wake ignored in run", mode, 2);

    // Reset again, both rails good from start
    por_n = 0;
    step(1);
    chk("R1 reassert mode", mode, 0);
    chk("R1 reassert clk_en", clk_en, 0);
    por_n = 1;
    wait_mode(1);
    step(STAB);
    chk("R4 both rails in check", mode, 1);
    step(1);
    chk("R4 both rails reach run", mode, 2);

    // Wake during settling ignored
    por_n = 0; v18 = 0; v33 = 1;
    step(2);
    por_n = 1;
    wait_mode(1);
    pulse_wake();
    chk("R10 wake in settle no pwr", pwr_en, 0);
    wait_mode(3);
    chk("R4 only 3V3 gives sleep", mode, 3);

    // Wake with bad rails: full fresh window then sleep
    v33 = 0;
    pulse_wake();
    n = 0;
    while (mode == 1 && n < 50) begin n++; step(1); end
    chk("R8 fresh window length", n, CHK);
    chk("R8 back to sleep", mode, 3);

    // Wake, rails good only in last check cycle
    pulse_wake();
    step(CHK - 1);
    chk("R6 still checking", mode, 1);
    v18 = 1; v33 = 1;
    step(1);
    chk("R6 last-cycle good gives run", mode, 2);

    step(2);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule